// File: doc/BRIEF.md
# Log-Redirecting Line Read Unit

This unit serves cache-miss line reads in a memory controller that keeps recently written data in a redo log instead of its home location. Each request carries a line address. The unit looks for the newest copy of that line, in fixed priority order. First it searches a small fully associative index of live log entries. If that misses, it searches an eviction buffer that holds whole lines counted as part of the memory image. Only when both miss does it read the home location.

A log entry may hold only some bytes of a line. Each index entry therefore carries a per-byte presence bitmap. On an index hit the unit reads the log slot first. If the bitmap is not full, it then reads the home line and builds the result byte by byte: log bytes where the bitmap is set, home bytes everywhere else. A full bitmap skips the home read. The complete 64-byte line goes back on a valid/ready response channel. Only one request is in flight at a time.

The index and the eviction buffer are filled through simple write ports by the log-generation logic, which is outside this unit. The memory side is a one-request port, and its fixed-latency response arrives as a single-cycle pulse.

Top module: `logread_path`

## Requirements
- R1: After reset `req_ready` is 1, while `rsp_valid` and `mem_req_valid` are 0.
- R2: When the index holds a valid entry whose address equals the request address, the unit issues exactly one log read (`mem_req_log`=1), and `mem_req_addr` carries that entry's slot number, zero-extended.
- R3: On an index hit with a partial bitmap, byte b of the returned line (bits 8b+7..8b) is taken from the log data when bitmap bit b is 1 and from the home line otherwise. The home line is read once, with `mem_req_log`=0 and `mem_req_addr` equal to the request address.
- R4: On an index hit with an all-ones bitmap, no home read is issued, and the line equals the log data.
- R5: When the index misses and a valid eviction-buffer entry matches, that entry's line is returned with no memory read at all.
- R6: When both the index and the eviction buffer miss, exactly one home read is issued, and the returned line equals the home data unchanged.
- R7: When the index and the eviction buffer both match the request address, the index wins (R2/R3 behaviour applies).
- R8: Only one request is outstanding: `req_ready` stays 0 from acceptance until the response handshake. `rsp_valid` stays 1 and `rsp_data` stays stable while `rsp_ready` is 0.
- R9: Writing an index entry with `map_wr_valid`=0 removes it, so later reads of that address fall through to the eviction buffer or home.
- R10: An index hit whose bitmap is all zeros still reads the log and then the home line, and it returns the home line unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Read request valid |
| req_ready | output | 1 | Unit idle, request accepted |
| req_addr | input | ADDR_W | Line address to read |
| rsp_valid | output | 1 | Assembled line available |
| rsp_ready | input | 1 | Consumer takes the line |
| rsp_data | output | LINE_BYTES*8 | Assembled line, byte b at bits 8b+7..8b |
| map_wr_en | input | 1 | Write one index entry |
| map_wr_idx | input | log2(MAP_N) | Index entry number |
| map_wr_valid | input | 1 | Entry live (0 removes it) |
| map_wr_addr | input | ADDR_W | Line address the entry covers |
| map_wr_slot | input | SLOT_W | Log slot holding the data |
| map_wr_mask | input | LINE_BYTES | Per-byte presence bitmap |
| evb_wr_en | input | 1 | Write one eviction-buffer entry |
| evb_wr_idx | input | log2(EVB_N) | Eviction-buffer entry number |
| evb_wr_valid | input | 1 | Entry live |
| evb_wr_addr | input | ADDR_W | Line address of the entry |
| evb_wr_data | input | LINE_BYTES*8 | Full line contents |
| mem_req_valid | output | 1 | One-cycle memory read pulse |
| mem_req_log | output | 1 | 1 = log slot read, 0 = home read |
| mem_req_addr | output | ADDR_W | Slot number or home line address |
| mem_resp_valid | input | 1 | One-cycle read data pulse |
| mem_resp_data | input | LINE_BYTES*8 | Read data |

## Verification
The index and the eviction buffer can both claim the same line in the same lookup cycle. The bench provokes this by installing an eviction-buffer copy of a line that already has a partial log entry. It judges the result by the returned bytes and by the count and kind of memory reads: one log read plus one home read and the merged line, never the buffer's line. It then removes the index entry and repeats the read, which must now return the buffer copy with no memory traffic at all. A behavioural model of both tables predicts every response. Each clock, the bench also checks that a response is never offered while a new request could be accepted.

// File: rtl/logread_path.sv
module logread_path #(
  parameter int ADDR_W     = 26,
  parameter int SLOT_W     = 8,
  parameter int LINE_BYTES = 64,
  parameter int MAP_N      = 16,
  parameter int EVB_N      = 4
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          req_valid,
  output logic                          req_ready,
  input  logic [ADDR_W-1:0]             req_addr,
  output logic                          rsp_valid,
  input  logic                          rsp_ready,
  output logic [LINE_BYTES*8-1:0]       rsp_data,
  input  logic                          map_wr_en,
  input  logic [$clog2(MAP_N)-1:0]      map_wr_idx,
  input  logic                          map_wr_valid,
  input  logic [ADDR_W-1:0]             map_wr_addr,
  input  logic [SLOT_W-1:0]             map_wr_slot,
  input  logic [LINE_BYTES-1:0]         map_wr_mask,
  input  logic                          evb_wr_en,
  input  logic [$clog2(EVB_N)-1:0]      evb_wr_idx,
  input  logic                          evb_wr_valid,
  input  logic [ADDR_W-1:0]             evb_wr_addr,
  input  logic [LINE_BYTES*8-1:0]       evb_wr_data,
  output logic                          mem_req_valid,
  output logic                          mem_req_log,
  output logic [ADDR_W-1:0]             mem_req_addr,
  input  logic                          mem_resp_valid,
  input  logic [LINE_BYTES*8-1:0]       mem_resp_data
);
  localparam int LINE_W = LINE_BYTES * 8;
  localparam int MI_W   = $clog2(MAP_N);
  localparam int EI_W   = $clog2(EVB_N);

  typedef enum logic [2:0] {S_IDLE, S_LOOK, S_ILOG, S_WLOG, S_IHOME, S_WHOME, S_RSP} st_t;
  st_t st;

  logic [MAP_N-1:0]      map_v;
  logic [ADDR_W-1:0]     map_tag  [MAP_N];
  logic [SLOT_W-1:0]     map_slot [MAP_N];
  logic [LINE_BYTES-1:0] map_mask [MAP_N];
  logic [EVB_N-1:0]      evb_v;
  logic [ADDR_W-1:0]     evb_tag  [EVB_N];
  logic [LINE_W-1:0]     evb_line [EVB_N];

  logic [ADDR_W-1:0]     cur_addr;
  logic [SLOT_W-1:0]     cur_slot;
  logic [LINE_BYTES-1:0] cur_mask;
  logic [LINE_W-1:0]     line_q, merged;
  logic                  m_hit, e_hit;
  logic [MI_W-1:0]       m_sel;
  logic [EI_W-1:0]       e_sel;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      map_v <= '0;
      evb_v <= '0;
    end else begin
      if (map_wr_en) begin
        map_v[map_wr_idx]    <= map_wr_valid;
        map_tag[map_wr_idx]  <= map_wr_addr;
        map_slot[map_wr_idx] <= map_wr_slot;
        map_mask[map_wr_idx] <= map_wr_mask;
      end
      if (evb_wr_en) begin
        evb_v[evb_wr_idx]    <= evb_wr_valid;
        evb_tag[evb_wr_idx]  <= evb_wr_addr;
        evb_line[evb_wr_idx] <= evb_wr_data;
      end
    end
  end

  always_comb begin
    m_hit = 1'b0;
    m_sel = '0;
    for (int i = MAP_N - 1; i >= 0; i--)
      if (map_v[i] && map_tag[i] == cur_addr) begin
        m_hit = 1'b1;
        m_sel = MI_W'(i);
      end
  end

  always_comb begin
    e_hit = 1'b0;
    e_sel = '0;
    for (int i = EVB_N - 1; i >= 0; i--)
      if (evb_v[i] && evb_tag[i] == cur_addr) begin
        e_hit = 1'b1;
        e_sel = EI_W'(i);
      end
  end

  for (genvar b = 0; b < LINE_BYTES; b++) begin : g_merge
    assign merged[8*b +: 8] = cur_mask[b] ? line_q[8*b +: 8] : mem_resp_data[8*b +: 8];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      cur_addr <= '0;
      cur_slot <= '0;
      cur_mask <= '0;
      line_q   <= '0;
    end else begin
      case (st)
        S_IDLE: if (req_valid) begin
          cur_addr <= req_addr;
          st       <= S_LOOK;
        end
        S_LOOK: if (m_hit) begin
          cur_slot <= map_slot[m_sel];
          cur_mask <= map_mask[m_sel];
          st       <= S_ILOG;
        end else if (e_hit) begin
          line_q <= evb_line[e_sel];
          st     <= S_RSP;
        end else begin
          cur_mask <= '0;
          st       <= S_IHOME;
        end
        S_ILOG:  st <= S_WLOG;
        S_WLOG: if (mem_resp_valid) begin
          line_q <= mem_resp_data;
          st     <= (&cur_mask) ? S_RSP : S_IHOME;
        end
        S_IHOME: st <= S_WHOME;
        S_WHOME: if (mem_resp_valid) begin
          line_q <= merged;
          st     <= S_RSP;
        end
        S_RSP: if (rsp_ready) st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  assign req_ready     = (st == S_IDLE);
  assign rsp_valid     = (st == S_RSP);
  assign rsp_data      = line_q;
  assign mem_req_valid = (st == S_ILOG) || (st == S_IHOME);
  assign mem_req_log   = (st == S_ILOG);
  assign mem_req_addr  = (st == S_ILOG) ? {{(ADDR_W-SLOT_W){1'b0}}, cur_slot} : cur_addr;
endmodule

module logread_path_chk #(
  parameter int ADDR_W = 26,
  parameter int LINE_W = 512
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic              rsp_valid,
  input logic              rsp_ready,
  input logic [LINE_W-1:0] rsp_data,
  input logic              mem_req_valid,
  input logic              mem_req_log,
  input logic [ADDR_W-1:0] mem_req_addr,
  input logic              mem_resp_valid
);
  a_r8_one_outstanding: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !req_ready);
  a_r8_rsp_hold: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_data));
  a_r8_accept_busy: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> !req_ready);
  a_r2_req_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |=> !mem_req_valid);
  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !mem_req_valid && !rsp_valid);
  a_r4_no_req_while_resp: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !mem_req_valid);
endmodule

bind logread_path logread_path_chk #(.ADDR_W(ADDR_W), .LINE_W(LINE_W)) u_chk (.*);

// File: tb/logread_path_tb.sv
module logread_path_tb;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 26, SLOT_W = 8, LB = 64, LW = LB * 8, MAP_N = 16, EVB_N = 4;
  localparam int LAT = 4;

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_ready, rsp_valid, rsp_ready = 0;
  logic [ADDR_W-1:0] req_addr = '0;
  logic [LW-1:0] rsp_data;
  logic map_wr_en = 0, map_wr_valid = 0;
  logic [3:0] map_wr_idx = '0;
  logic [ADDR_W-1:0] map_wr_addr = '0;
  logic [SLOT_W-1:0] map_wr_slot = '0;
  logic [LB-1:0] map_wr_mask = '0;
  logic evb_wr_en = 0, evb_wr_valid = 0;
  logic [1:0] evb_wr_idx = '0;
  logic [ADDR_W-1:0] evb_wr_addr = '0;
  logic [LW-1:0] evb_wr_data = '0;
  logic mem_req_valid, mem_req_log;
  logic [ADDR_W-1:0] mem_req_addr;
  logic mem_resp_valid = 0;
  logic [LW-1:0] mem_resp_data = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  logread_path u_dut (.*);

  int checks = 0, failures = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string tag, input string msg);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s: %s", tag, msg);
    end
  endtask

  function automatic logic [LW-1:0] home_line(input logic [ADDR_W-1:0] a);
    logic [LW-1:0] r;
    for (int b = 0; b < LB; b++) r[8*b +: 8] = 8'(a * 7 + b * 3 + 1);
    return r;
  endfunction

  function automatic logic [LW-1:0] log_line(input logic [ADDR_W-1:0] s);
    logic [LW-1:0] r;
    for (int b = 0; b < LB; b++) r[8*b +: 8] = 8'(s * 11 + b * 5 + 8'h90);
    return r;
  endfunction

  // fixed-latency memory model with traffic counters
  logic mpend = 0, mlog = 0;
  int mcnt = 0;
  logic [ADDR_W-1:0] maddr = '0;
  int n_log = 0, n_home = 0;
  logic [ADDR_W-1:0] last_log_addr = '0, last_home_addr = '0;
  always @(posedge clk) begin
    mem_resp_valid <= 1'b0;
    if (mpend) begin
      if (mcnt == 1) begin
        mem_resp_valid <= 1'b1;
        mem_resp_data  <= mlog ? log_line(maddr) : home_line(maddr);
        mpend <= 1'b0;
      end else mcnt <= mcnt - 1;
    end
    if (mem_req_valid) begin
      mpend <= 1'b1; mcnt <= LAT; mlog <= mem_req_log; maddr <= mem_req_addr;
      if (mem_req_log) begin n_log <= n_log + 1; last_log_addr <= mem_req_addr; end
      else begin n_home <= n_home + 1; last_home_addr <= mem_req_addr; end
    end
  end

  // every-clock check of the single-outstanding rule
  always @(negedge clk)
    if (rst_n && !done) chk(!(rsp_valid && req_ready), "R8",
      $sformatf("rsp_valid=%0b req_ready=%0b expected not both 1", rsp_valid, req_ready));

  // behavioural mirror of both tables
  bit m_v[MAP_N]; logic [ADDR_W-1:0] m_a[MAP_N]; logic [SLOT_W-1:0] m_s[MAP_N]; logic [LB-1:0] m_m[MAP_N];
  bit e_v[EVB_N]; logic [ADDR_W-1:0] e_a[EVB_N]; logic [LW-1:0] e_d[EVB_N];

  task automatic map_put(input int i, input bit v, input int a, input int s, input logic [LB-1:0] m);
    @(negedge clk);
    map_wr_en = 1; map_wr_idx = 4'(i); map_wr_valid = v; map_wr_addr = ADDR_W'(a);
    map_wr_slot = SLOT_W'(s); map_wr_mask = m;
    @(negedge clk);
    map_wr_en = 0;
    m_v[i] = v; m_a[i] = ADDR_W'(a); m_s[i] = SLOT_W'(s); m_m[i] = m;
  endtask

  task automatic evb_put(input int i, input bit v, input int a, input logic [LW-1:0] d);
    @(negedge clk);
    evb_wr_en = 1; evb_wr_idx = 2'(i); evb_wr_valid = v; evb_wr_addr = ADDR_W'(a); evb_wr_data = d;
    @(negedge clk);
    evb_wr_en = 0;
    e_v[i] = v; e_a[i] = ADDR_W'(a); e_d[i] = d;
  endtask

  task automatic do_read(input int a, input int hold, input string tag);
    logic [LW-1:0] exp_d, lg, hm;
    int exp_nl, exp_nh, l0, h0, mi, ei, wait_n;
    logic [LW-1:0] first;
    mi = -1; ei = -1;
    for (int i = MAP_N - 1; i >= 0; i--) if (m_v[i] && m_a[i] == ADDR_W'(a)) mi = i;
    for (int i = EVB_N - 1; i >= 0; i--) if (e_v[i] && e_a[i] == ADDR_W'(a)) ei = i;
    hm = home_line(ADDR_W'(a));
    if (mi >= 0) begin
      lg = log_line(ADDR_W'(m_s[mi]));
      exp_nl = 1; exp_nh = (&m_m[mi]) ? 0 : 1;
      for (int b = 0; b < LB; b++) exp_d[8*b +: 8] = m_m[mi][b] ? lg[8*b +: 8] : hm[8*b +: 8];
    end else if (ei >= 0) begin
      exp_nl = 0; exp_nh = 0; exp_d = e_d[ei];
    end else begin
      exp_nl = 0; exp_nh = 1; exp_d = hm;
    end
    @(negedge clk);
    chk(req_ready === 1'b1, tag, $sformatf("req_ready=%0b expected 1 before request", req_ready));
    l0 = n_log; h0 = n_home;
    req_valid = 1; req_addr = ADDR_W'(a);
    @(negedge clk);
    req_valid = 0;
    wait_n = 0;
    while (rsp_valid !== 1'b1 && wait_n < 100) begin
      if (req_ready !== 1'b0) chk(0, "R8", $sformatf("req_ready=%0b expected 0 while busy", req_ready));
      @(negedge clk); wait_n++;
    end
    chk(rsp_valid === 1'b1, tag, $sformatf("rsp_valid=%0b expected 1", rsp_valid));
    first = rsp_data;
    for (int k = 0; k < hold; k++) begin
      @(negedge clk);
      chk(rsp_valid === 1'b1 && rsp_data === first, "R8",
          $sformatf("held rsp_valid=%0b data changed=%0b expected 1/0", rsp_valid, rsp_data !== first));
    end
    chk(rsp_data === exp_d, tag, $sformatf("data=%h expected %h", rsp_data, exp_d));
    chk(n_log - l0 == exp_nl, tag, $sformatf("log reads=%0d expected %0d", n_log - l0, exp_nl));
    chk(n_home - h0 == exp_nh, tag, $sformatf("home reads=%0d expected %0d", n_home - h0, exp_nh));
    if (exp_nl == 1) chk(last_log_addr == ADDR_W'(m_s[mi]), tag,
      $sformatf("log addr=%0d expected %0d", last_log_addr, m_s[mi]));
    if (exp_nh == 1) chk(last_home_addr == ADDR_W'(a), tag,
      $sformatf("home addr=%0d expected %0d", last_home_addr, a));
    rsp_ready = 1;
    @(negedge clk);
    rsp_ready = 0;
    chk(rsp_valid === 1'b0 && req_ready === 1'b1, "R8",
        $sformatf("after handshake rsp_valid=%0b req_ready=%0b expected 0/1", rsp_valid, req_ready));
  endtask

  logic [LW-1:0] pat;

  initial begin
    for (int i = 0; i < MAP_N; i++) m_v[i] = 0;
    for (int i = 0; i < EVB_N; i++) e_v[i] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1
    chk(req_ready === 1 && rsp_valid === 0 && mem_req_valid === 0, "R1",
        $sformatf("ready=%0b rsp=%0b mreq=%0b expected 1/0/0", req_ready, rsp_valid, mem_req_valid));
    // R6: both miss
    do_read(100, 0, "R6");
    // R2/R3: partial log entry
    map_put(3, 1, 200, 5, 64'hA5A5_0F0F_3C3C_F0F0);
    do_read(200, 2, "R3");
    // R4: full bitmap skips home
    map_put(7, 1, 300, 9, '1);
    do_read(300, 0, "R4");
    // R5: eviction buffer hit
    for (int b = 0; b < LB; b++) pat[8*b +: 8] = 8'(8'h3C ^ b);
    evb_put(1, 1, 400, pat);
    do_read(400, 1, "R5");
    // R7: both index and eviction buffer hold line 200
    for (int b = 0; b < LB; b++) pat[8*b +: 8] = 8'(8'hE1 + b * 2);
    evb_put(2, 1, 200, pat);
    do_read(200, 0, "R7");
    // R9: removing the index entry exposes the buffer copy
    map_put(3, 0, 200, 5, 64'hA5A5_0F0F_3C3C_F0F0);
    do_read(200, 0, "R9");
    // R10: empty bitmap still reads log then home
    map_put(0, 1, 500, 17, '0);
    do_read(500, 0, "R10");
    // R2: a different slot and a higher index entry
    map_put(15, 1, 600, 200, 64'h0000_0000_FFFF_0001);
    do_read(600, 3, "R2");
    do_read(700, 0, "R6");
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    done = 1;
    checks++; failures++;
    $display("FAIL watchdog: run did not finish, actual=timeout expected=completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule